// File: doc/BRIEF.md
# Pushed Compare Transfer Sequencer

This block sits inside a debug port, between the host-facing register set and a memory access port. One host access, with a transfer count loaded, becomes a burst of internal accesses at ascending addresses, run at internal clock speed with no further host traffic. In the plain mode a host write becomes a block fill and a host read becomes a burst of reads. In the two pushed modes the host value is never written to the target. It is kept as a reference, and the sequencer reads each word and compares it, under a bit mask, against that reference.

Memory verify triggers on the first mismatch. Search triggers on the first match. A trigger ends the burst, raises a sticky compare flag and captures the address that caused it. The host can then learn pass or fail, and where a failure occurred, from one status read instead of reading the whole block back. A bus error response also ends the burst, through a separate sticky flag. While either flag is set, new host requests are dropped until software clears that flag.

Top module: `ptc_seq`

## Requirements
- R1: After reset, `busy`, `bus_req`, `cmp_flag` and `err_flag` are low, and `fail_addr` and `rd_data` are zero.
- R2: An accepted request performs N internal accesses when `cfg_count` is N > 0 and exactly one access when it is 0. The accesses start at `cfg_addr` and step by +1 (modulo 2^AW). Each access holds `bus_req`, `bus_addr` and `bus_we` steady until `bus_rsp_valid`.
- R3: In mode 2'b00, a host write (`host_write`=1) writes `host_wdata` to every address of the burst. A host read performs bus reads only. `rd_data` shows the data of the most recent error-free read response.
- R4: In mode 2'b01 (verify), every access is a read. The burst triggers on the first word where `(rdata ^ host_wdata) & cfg_mask` is non-zero.
- R5: In mode 2'b10 (search), every access is a read. The burst triggers on the first word where `(rdata ^ host_wdata) & cfg_mask` is zero.
- R6: Mode 2'b11 behaves exactly as mode 2'b00.
- R7: A trigger ends the burst after the triggering access. It sets `cmp_flag` and loads `fail_addr` with the triggering address. A burst that ends with no trigger leaves `cmp_flag` and `fail_addr` unchanged.
- R8: A response with `bus_rsp_err` ends the burst, sets `err_flag` and loads `fail_addr` with that access's address. An errored write does not update memory, and an errored read does not update `rd_data`.
- R9: While `cmp_flag` or `err_flag` is set, `host_req` causes no bus access and `busy` stays low. Each flag stays set until its own clear input (`clr_cmp`, `clr_err`) is pulsed.
- R10: `busy` is high from the cycle after an accepted request until the cycle after the final response. A `host_req` while busy is ignored, and configuration inputs changed during a burst do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle pulse starting a host access |
| host_write | input | 1 | Host access is a write |
| host_wdata | input | DW | Write data, or reference value in pushed modes |
| cfg_mode | input | 2 | Transfer mode: 00 plain, 01 verify, 10 search, 11 plain |
| cfg_count | input | CW | Transfer count, 0 meaning one access |
| cfg_addr | input | AW | Start address of the burst |
| cfg_mask | input | DW | Compare mask, 1 = bit takes part |
| clr_cmp | input | 1 | Clears the compare flag |
| clr_err | input | 1 | Clears the error flag |
| busy | output | 1 | Burst in progress |
| rd_data | output | DW | Data of the latest good read |
| cmp_flag | output | 1 | Sticky compare trigger flag |
| err_flag | output | 1 | Sticky bus error flag |
| fail_addr | output | AW | Address of the trigger or error |
| bus_req | output | 1 | Internal access request |
| bus_we | output | 1 | Internal access is a write |
| bus_addr | output | AW | Internal access address |
| bus_wdata | output | DW | Internal write data |
| bus_rsp_valid | input | 1 | Response for the pending access |
| bus_rsp_err | input | 1 | Response carries an error |
| bus_rdata | input | DW | Read data of the response |

## Verification
Most internal faults show up at the ports during the burst itself. A wrong remaining count shows as one access too many or too few. A wrong address register makes the walk skip or repeat an address, and the fill leaves the wrong memory words written. A faulty masked comparator moves the trigger, so both `fail_addr` and the access count differ by the next status read. A sticky flag that fails to hold, or fails to block requests, shows as bus activity on the very next host request after a trigger or error.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    XM_PLAIN  = 2'b00,
    XM_VERIFY = 2'b01,
    XM_FIND   = 2'b10,
    XM_SPARE  = 2'b11
  } xfer_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;

  function automatic logic mode_is_pushed(input logic [1:0] m);
    return (m == XM_VERIFY) || (m == XM_FIND);
  endfunction

endpackage

// File: rtl/ptc_match.sv
module ptc_match #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rdat,
  input  logic [DW-1:0] expv,
  input  logic [DW-1:0] mask,
  output logic          equal
);

  logic [DW-1:0] diff_bits;

  // per-bit masked difference
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign diff_bits[b] = mask[b] & (rdat[b] ^ expv[b]);
  end

  assign equal = ~|diff_bits;

endmodule

// File: rtl/ptc_walker.sv
module ptc_walker #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_cnt,
  output logic [AW-1:0] addr,
  output logic          last
);

  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [AW-1:0] ADDR_INC = AW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          en;

  assign en = load | step;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (load) begin
      cnt_d  = (start_cnt == '0) ? CNT_ONE : start_cnt;
      addr_d = start_addr;
    end else if (step) begin
      cnt_d  = cnt_q - CNT_ONE;
      addr_d = addr_q + ADDR_INC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;
  assign last = (cnt_q == CNT_ONE);

endmodule

// File: rtl/ptc_status.sv
module ptc_status #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_cmp,
  input  logic          set_err,
  input  logic          clr_cmp,
  input  logic          clr_err,
  input  logic [AW-1:0] cap_addr,
  output logic          cmp_flag,
  output logic          err_flag,
  output logic [AW-1:0] fail_addr
);

  logic          cmp_q, cmp_d, err_q, err_d;
  logic [AW-1:0] fa_q;
  logic          fa_en;

  // a set in the same cycle as a clear wins
  always_comb begin
    cmp_d = cmp_q;
    err_d = err_q;
    if (clr_cmp) cmp_d = 1'b0;
    if (set_cmp) cmp_d = 1'b1;
    if (clr_err) err_d = 1'b0;
    if (set_err) err_d = 1'b1;
  end

  assign fa_en = set_cmp | set_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fa_q <= '0;
    else if (fa_en) fa_q <= cap_addr;
  end

  assign cmp_flag  = cmp_q;
  assign err_flag  = err_q;
  assign fail_addr = fa_q;

endmodule

// File: rtl/ptc_seq.sv
module ptc_seq
  import ptc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_write,
  input  logic [DW-1:0] host_wdata,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_mask,
  input  logic          clr_cmp,
  input  logic          clr_err,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          cmp_flag,
  output logic          err_flag,
  output logic [AW-1:0] fail_addr,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_rsp_valid,
  input  logic          bus_rsp_err,
  input  logic [DW-1:0] bus_rdata
);

  seq_state_e    st_q, st_d;
  logic [DW-1:0] expv_q, mask_q, rd_q;
  logic [1:0]    mode_q;
  logic          we_q;
  logic          accept, rsp, trig, last, stop, step, eq;
  logic          set_cmp, set_err, rd_en;
  logic [AW-1:0] cur_addr;

  assign accept = host_req && (st_q == SQ_IDLE) && !cmp_flag && !err_flag;
  assign rsp    = (st_q == SQ_RUN) && bus_rsp_valid;

  always_comb begin
    case (mode_q)
      XM_VERIFY: trig = !eq;
      XM_FIND:   trig = eq;
      default:   trig = 1'b0;
    endcase
  end

  assign set_err = rsp && bus_rsp_err;
  assign set_cmp = rsp && !bus_rsp_err && trig;
  assign stop    = rsp && (bus_rsp_err || trig || last);
  assign step    = rsp && !stop;
  assign rd_en   = rsp && !we_q && !bus_rsp_err;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (accept) st_d = SQ_RUN;
      SQ_RUN:  if (stop)   st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // burst context, captured once per accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expv_q <= '0;
      mask_q <= '0;
      mode_q <= XM_PLAIN;
      we_q   <= 1'b0;
    end else if (accept) begin
      expv_q <= host_wdata;
      mask_q <= cfg_mask;
      mode_q <= cfg_mode;
      we_q   <= host_write && !mode_is_pushed(cfg_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= bus_rdata;
  end

  ptc_match #(.DW(DW)) u_match (
    .rdat  (bus_rdata),
    .expv  (expv_q),
    .mask  (mask_q),
    .equal (eq)
  );

  ptc_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .step       (step),
    .start_addr (cfg_addr),
    .start_cnt  (cfg_count),
    .addr       (cur_addr),
    .last       (last)
  );

  ptc_status #(.AW(AW)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_cmp   (set_cmp),
    .set_err   (set_err),
    .clr_cmp   (clr_cmp),
    .clr_err   (clr_err),
    .cap_addr  (cur_addr),
    .cmp_flag  (cmp_flag),
    .err_flag  (err_flag),
    .fail_addr (fail_addr)
  );

  assign busy      = (st_q == SQ_RUN);
  assign bus_req   = (st_q == SQ_RUN);
  assign bus_we    = we_q;
  assign bus_addr  = cur_addr;
  assign bus_wdata = expv_q;
  assign rd_data   = rd_q;

endmodule

// File: rtl/ptc_seq_chk.sv
module ptc_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_cmp,
  input logic          clr_err,
  input logic          busy,
  input logic          cmp_flag,
  input logic          err_flag,
  input logic [AW-1:0] fail_addr,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rsp_valid,
  input logic          bus_rsp_err,
  input logic [DW-1:0] bus_rdata
);

  logic [DW-1:0] unused_rdata;
  assign unused_rdata = bus_rdata;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rsp_valid |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_rsp_valid |=> !bus_req || (bus_addr == AW'($past(bus_addr) + 1'b1)));

  assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_rsp_valid && bus_rsp_err |=>
      err_flag && !bus_req && (fail_addr == $past(bus_addr)));

  assert_cmp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag && !clr_cmp |=> cmp_flag);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_err |=> err_flag);

  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (cmp_flag || err_flag) |=> !busy);

  assert_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> !bus_req && $past(bus_req) && $past(bus_rsp_valid));

endmodule

bind ptc_seq ptc_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr_cmp       (clr_cmp),
  .clr_err       (clr_err),
  .busy          (busy),
  .cmp_flag      (cmp_flag),
  .err_flag      (err_flag),
  .fail_addr     (fail_addr),
  .bus_req       (bus_req),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_rsp_valid (bus_rsp_valid),
  .bus_rsp_err   (bus_rsp_err),
  .bus_rdata     (bus_rdata)
);

// File: tb/ptc_seq_test.sv
module ptc_seq_test;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int CW = 5;
  localparam int NW = 1 << AW;

  logic          clk, rst_n;
  logic          host_req, host_write;
  logic [DW-1:0] host_wdata, cfg_mask;
  logic [1:0]    cfg_mode;
  logic [CW-1:0] cfg_count;
  logic [AW-1:0] cfg_addr;
  logic          clr_cmp, clr_err;
  logic          busy, cmp_flag, err_flag;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] fail_addr;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          rsp_valid, rsp_err;

  logic          err_en;
  logic [AW-1:0] err_at;
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] exp_mem [NW];
  logic          exp_cmp, exp_err;
  logic [AW-1:0] exp_fa;
  logic [DW-1:0] exp_rd;
  int            vectors, fails, acc_cnt;

  ptc_seq #(.DW(DW), .AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
    .host_wdata(host_wdata), .cfg_mode(cfg_mode), .cfg_count(cfg_count),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .clr_cmp(clr_cmp), .clr_err(clr_err),
    .busy(busy), .rd_data(rd_data), .cmp_flag(cmp_flag), .err_flag(err_flag),
    .fail_addr(fail_addr), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rsp_valid(rsp_valid), .bus_rsp_err(rsp_err),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] init_val(input int i);
    return DW'(i * 16'h0137 + 16'h0042);
  endfunction

  // memory responder: one response per request, one cycle after it appears
  assign rsp_err   = rsp_valid && err_en && (bus_addr == err_at);
  assign bus_rdata = mem[bus_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      for (int i = 0; i < NW; i++) mem[i] <= init_val(i);
    end else begin
      rsp_valid <= bus_req && !rsp_valid;
      if (rsp_valid && bus_we && !rsp_err) mem[bus_addr] <= bus_wdata;
    end
  end

  always @(posedge clk) if (rsp_valid) acc_cnt <= acc_cnt + 1;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic clear(input bit c, input bit e);
    @(negedge clk);
    clr_cmp = c; clr_err = e;
    @(negedge clk);
    clr_cmp = 1'b0; clr_err = 1'b0;
    if (c) exp_cmp = 1'b0;
    if (e) exp_err = 1'b0;
    chk("R9", "cmp after clear", {31'b0, cmp_flag}, {31'b0, exp_cmp});
    chk("R9", "err after clear", {31'b0, err_flag}, {31'b0, exp_err});
  endtask

  task automatic run(input bit wr, input logic [1:0] md, input int cnt, input int ad,
                     input logic [DW-1:0] wd, input logic [DW-1:0] mk, input bit poke,
                     input string rq);
    int n, acc, a0, t, bad;
    logic [DW-1:0] diff;
    acc = 0;
    if (!exp_cmp && !exp_err) begin
      n = (cnt == 0) ? 1 : cnt;
      for (int i = 0; i < n; i++) begin
        int a;
        a = (ad + i) % NW;
        acc++;
        if (err_en && a == int'(err_at)) begin
          exp_err = 1'b1; exp_fa = AW'(a);
          break;
        end
        if (md == 2'b01 || md == 2'b10) begin
          exp_rd = exp_mem[a];
          diff = (exp_mem[a] ^ wd) & mk;
          if ((md == 2'b01 && diff != 0) || (md == 2'b10 && diff == 0)) begin
            exp_cmp = 1'b1; exp_fa = AW'(a);
            break;
          end
        end else if (wr) exp_mem[a] = wd;
        else exp_rd = exp_mem[a];
      end
    end
    a0 = acc_cnt;
    @(negedge clk);
    host_req = 1'b1; host_write = wr; cfg_mode = md; cfg_count = CW'(cnt);
    cfg_addr = AW'(ad); host_wdata = wd; cfg_mask = mk;
    @(negedge clk);
    host_req = 1'b0;
    if (acc > 0) chk("R10", "busy after accept", {31'b0, busy}, 32'd1);
    else         chk("R9", "busy while flagged", {31'b0, busy}, 32'd0);
    if (poke) begin
      host_req = 1'b1; cfg_addr = '0; host_wdata = '1; cfg_count = CW'(5); host_write = 1'b1;
      cfg_mode = 2'b00;
      @(negedge clk);
      host_req = 1'b0;
    end
    t = 0;
    while (busy && t < 400) begin @(negedge clk); t++; end
    if (t >= 400) begin
      vectors++; fails++;
      $display("FAIL R10 burst never ended: actual busy 1 expected 0");
    end
    @(negedge clk);
    chk(rq, "access count", 32'(acc_cnt - a0), 32'(acc));
    chk(rq, "cmp_flag", {31'b0, cmp_flag}, {31'b0, exp_cmp});
    chk(rq, "err_flag", {31'b0, err_flag}, {31'b0, exp_err});
    chk(rq, "fail_addr", 32'(fail_addr), 32'(exp_fa));
    chk(rq, "rd_data", 32'(rd_data), 32'(exp_rd));
    bad = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(rq, "memory words differing", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    vectors = 0; fails = 0; acc_cnt = 0;
    host_req = 0; host_write = 0; host_wdata = '0; cfg_mode = 2'b00; cfg_count = '0;
    cfg_addr = '0; cfg_mask = '1; clr_cmp = 0; clr_err = 0; err_en = 0; err_at = '0;
    exp_cmp = 0; exp_err = 0; exp_fa = '0; exp_rd = '0;
    for (int i = 0; i < NW; i++) exp_mem[i] = init_val(i);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "bus_req", {31'b0, bus_req}, 32'd0);
    chk("R1", "flags", {30'b0, cmp_flag, err_flag}, 32'd0);
    chk("R1", "fail_addr", 32'(fail_addr), 32'd0);
    chk("R1", "rd_data", 32'(rd_data), 32'd0);

    // R2/R3 fill sweep over counts, including count 0 = one access
    for (int c = 0; c <= 4; c++) run(1'b1, 2'b00, c, c * 3, DW'(16'hA500 + c), '1, 1'b0, "R2");
    // R3 plain reads, R6 spare mode as plain (read, and write across the top)
    run(1'b0, 2'b00, 3, 2, 16'h0000, '1, 1'b0, "R3");
    run(1'b0, 2'b11, 2, 8, 16'h0000, '1, 1'b0, "R6");
    run(1'b1, 2'b11, 3, 14, 16'h5A5A, '1, 1'b0, "R6");
    // R10 host request and config changes during a burst have no effect
    run(1'b1, 2'b00, 3, 9, 16'h7777, '1, 1'b1, "R10");

    // R4 verify: clean block passes, a corrupted word triggers
    run(1'b1, 2'b00, 8, 0, 16'h1234, '1, 1'b0, "R3");
    run(1'b0, 2'b01, 8, 0, 16'h1234, '1, 1'b0, "R4");
    run(1'b1, 2'b00, 1, 5, 16'h1334, '1, 1'b0, "R3");
    run(1'b1, 2'b01, 8, 0, 16'h1234, '1, 1'b0, "R7");
    // R9 flagged: a fill is dropped
    run(1'b1, 2'b00, 4, 0, 16'hDEAD, '1, 1'b0, "R9");
    clear(1'b1, 1'b0);
    // R4 mask excluding the corrupted bit passes
    run(1'b1, 2'b01, 8, 0, 16'h1234, 16'hFEFF, 1'b0, "R4");
    // R4 single-bit mask sweep on the corrupted word
    for (int k = 0; k < DW; k++) begin
      run(1'b1, 2'b01, 1, 5, 16'h1234, DW'(1 << k), 1'b0, "R4");
      if (exp_cmp) clear(1'b1, 1'b0);
    end
    // R5 search: exact match, masked match, no match
    run(1'b1, 2'b10, 8, 0, 16'h1334, '1, 1'b0, "R5");
    clear(1'b1, 1'b0);
    run(1'b1, 2'b10, 8, 1, 16'hFF34, 16'h00FF, 1'b0, "R5");
    clear(1'b1, 1'b0);
    run(1'b1, 2'b10, 6, 0, 16'hBEEF, '1, 1'b0, "R7");

    // R8 error mid fill, then blocked, then cleared
    err_en = 1'b1; err_at = 4'd10;
    run(1'b1, 2'b00, 4, 8, 16'hC0DE, '1, 1'b0, "R8");
    run(1'b0, 2'b01, 2, 0, 16'h1234, '1, 1'b0, "R9");
    clear(1'b0, 1'b1);
    run(1'b0, 2'b00, 2, 9, 16'h0000, '1, 1'b0, "R8");
    clear(1'b0, 1'b1);
    err_en = 1'b0;
    run(1'b0, 2'b00, 3, 8, 16'h0000, '1, 1'b0, "R3");

    summary();
    $finish;
  end

endmodule